// File: doc/BRIEF.md
# Matrix Keypad Scan Register Block

This block is the register side of a matrix keypad controller. A decoded key event arrives as an 8-bit code: the top bit says the key went up and the low seven bits select an entry in a lookup table. Each entry holds a row, a column and a valid flag. The block turns each event into a bit in one of several multi-key status words. Each status word covers two adjacent matrix columns. It can also raise a matrix interrupt.

Software reaches the block through a simple 32-bit read/write port with a one-cycle read latency. The port gives access to a control word, to the status words, and to storage words for the direct-key, encoder, matrix-key, scan and debounce settings. Some flags in those words clear when software reads them. The lookup table is filled through a separate configuration port. The block does not drive the keypad lines, time any debounce or count encoder steps.

Top module: `kpad_scan_regs`

## Requirements
- R1: After reset every register reads zero, every lookup entry is invalid and `kp_irq` is low.
- R2: A write stores the full 32-bit value at its offset, with no side effects, and a later read returns it. Offsets are 8 bytes apart from 0x00: control, direct key, encoder, matrix key, scan, then the multi-key words (4 by default, from 0x28), then debounce.
- R3: A key event has no effect on any register or on `kp_irq` while control bit 12 (matrix enable) is clear.
- R4: An enabled event is accepted only if control bit 30 (single scan) or bit 29 (scan on activity) is set. An accepted event clears bit 30 even when its lookup entry turns out invalid.
- R5: An accepted event whose lookup entry is invalid changes no multi-key word and raises no interrupt.
- R6: A press of the key at row r, column c sets bit r + 16*(c mod 2) of multi-key word c/2. Bits already set in that word are kept.
- R7: A release (code bit 7 set) clears the whole multi-key word of that key's column pair. The other words are untouched.
- R8: A valid accepted event sets control bit 22 and drives `kp_irq` high when control bit 11 is set. It does neither when bit 11 is clear.
- R9: A read of the control word returns its value before any change. It then clears bits 22 and 5 and drops `kp_irq`.
- R10: A read of the encoder word clears bits 31, 30, 15 and 14 after returning them. A read of the matrix-key word clears bit 31. A read of any other word clears nothing.
- R11: A read of an offset that is not 8-byte aligned, or that lies beyond the last register, returns zero and changes no state.
- R12: When a control read and an interrupting event fall in the same cycle, the read returns the old value, and both bit 22 and `kp_irq` end up set.
- R13: A write on the configuration port loads the row, column and valid flag of one lookup entry, and later events use the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe (takes precedence over bus_rd) |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_rd |
| key_valid | input | 1 | Key event strobe |
| key_code | input | CODE_W | Key code: top bit release, low bits table index |
| map_wr | input | 1 | Lookup table load strobe |
| map_idx | input | CODE_W-1 | Lookup entry index |
| map_ok | input | 1 | Entry holds a real key |
| map_row | input | ROW_W | Entry row |
| map_col | input | COL_W | Entry column |
| kp_irq | output | 1 | Matrix interrupt |

## Verification
Key presses are sent to columns 0, 1 and 6, so that both halves of a word and a far word are hit. This checks the even/odd packing and the word selection separately. Events are also sent with matrix enable off, with no scan mode on, with a single-scan mode on, and with an unloaded table entry; each one tells a different gating condition apart. Releases are checked to clear only their own pair. The read-clear flags are read twice to show the value before and after. A control read and an event are placed in the same cycle, which shows that the set wins.

// File: rtl/kpad_pkg.sv
package kpad_pkg;
   // control word bit positions
   localparam int CTL_SINGLE_SCAN = 30;
   localparam int CTL_SCAN_ACT    = 29;
   localparam int CTL_MTX_FLAG    = 22;
   localparam int CTL_MTX_EN      = 12;
   localparam int CTL_MTX_IE      = 11;
   localparam int CTL_DIR_FLAG    = 5;
   // read-clear flag positions
   localparam int ENC_HI_OVF = 31;
   localparam int ENC_HI_UNF = 30;
   localparam int ENC_LO_OVF = 15;
   localparam int ENC_LO_UNF = 14;
   localparam int MTX_PRESS  = 31;
   // fixed word slots ahead of the multi-key words
   localparam int SLOT_CTRL  = 0;
   localparam int SLOT_DIR   = 1;
   localparam int SLOT_ENC   = 2;
   localparam int SLOT_MTX   = 3;
   localparam int SLOT_SCAN  = 4;
   localparam int SLOT_MK0   = 5;
   localparam int FIXED_SLOTS = 6; // five ahead of the group plus debounce
endpackage

// File: rtl/kpad_keymap.sv
module kpad_keymap #(
   parameter int KEYS  = 128,
   parameter int ROW_W = 3,
   parameter int COL_W = 3,
   localparam int IDX_W = $clog2(KEYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic [IDX_W-1:0] ld_idx,
   input  logic             ld_ok,
   input  logic [ROW_W-1:0] ld_row,
   input  logic [COL_W-1:0] ld_col,
   input  logic [IDX_W-1:0] lk_idx,
   output logic             lk_ok,
   output logic [ROW_W-1:0] lk_row,
   output logic [COL_W-1:0] lk_col
);
   logic             ok_q  [KEYS];
   logic [ROW_W-1:0] row_q [KEYS];
   logic [COL_W-1:0] col_q [KEYS];

   for (genvar k = 0; k < KEYS; k++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ok_q[k]  <= 1'b0;
            row_q[k] <= '0;
            col_q[k] <= '0;
         end else if (ld_en && (ld_idx == IDX_W'(k))) begin
            ok_q[k]  <= ld_ok;
            row_q[k] <= ld_row;
            col_q[k] <= ld_col;
         end
      end
   end

   assign lk_ok  = ok_q[lk_idx];
   assign lk_row = row_q[lk_idx];
   assign lk_col = col_q[lk_idx];
endmodule

// File: rtl/kpad_event.sv
module kpad_event
   import kpad_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ROWS   = 8,
   parameter int COLS   = 8,
   parameter int ROW_W  = 3,
   parameter int COL_W  = 3,
   localparam int NPAIR = COLS / 2,
   localparam int HALF  = DATA_W / 2
) (
   input  logic              key_valid,
   input  logic              key_up,
   input  logic [DATA_W-1:0] ctrl,
   input  logic              ent_ok,
   input  logic [ROW_W-1:0]  ent_row,
   input  logic [COL_W-1:0]  ent_col,
   output logic              ev_arm,
   output logic              ev_take,
   output logic              ev_rel,
   output logic              ev_irq,
   output logic [NPAIR-1:0]  ev_sel,
   output logic [DATA_W-1:0] ev_mask
);
   logic in_range;
   logic [DATA_W-1:0] one;

   assign in_range = (32'(ent_row) < ROWS) && (32'(ent_col) < COLS);
   assign ev_arm   = key_valid && ctrl[CTL_MTX_EN] &&
                     (ctrl[CTL_SINGLE_SCAN] || ctrl[CTL_SCAN_ACT]);
   assign ev_take  = ev_arm && ent_ok && in_range;
   assign ev_rel   = key_up;
   assign ev_irq   = ev_take && ctrl[CTL_MTX_IE];
   assign one      = DATA_W'(1);

   always_comb begin
      ev_mask = one << (32'(ent_row) + (ent_col[0] ? HALF : 0));
   end

   for (genvar p = 0; p < NPAIR; p++) begin : g_sel
      assign ev_sel[p] = (32'(ent_col >> 1) == p);
   end
endmodule

// File: rtl/kpad_regs.sv
module kpad_regs
   import kpad_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int NPAIR  = 4,
   localparam int NREG  = FIXED_SLOTS + NPAIR,
   localparam int SLOT_W = $clog2(NREG)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_wr,
   input  logic                    bus_rd,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   input  logic                    ev_arm,
   input  logic                    ev_take,
   input  logic                    ev_rel,
   input  logic                    ev_irq,
   input  logic [NPAIR-1:0]        ev_sel,
   input  logic [DATA_W-1:0]       ev_mask,
   output logic [DATA_W-1:0]       ctrl_w,
   output logic [NPAIR*DATA_W-1:0] mk_flat,
   output logic                    irq
);
   logic [DATA_W-1:0] rf_q [NREG];
   logic [DATA_W-1:0] rf_d [NREG];
   logic              irq_q, irq_d;
   logic [DATA_W-1:0] rdata_q;
   logic              hit;
   logic [SLOT_W-1:0] slot;
   logic              wr_go, rd_go;

   assign hit   = (bus_addr[2:0] == 3'b000) &&
                  (32'(bus_addr >> 3) < NREG);
   assign slot  = SLOT_W'(bus_addr >> 3);
   assign wr_go = bus_wr && hit;
   assign rd_go = bus_rd && !bus_wr && hit;

   always_comb begin
      for (int i = 0; i < NREG; i++) rf_d[i] = rf_q[i];
      irq_d = irq_q;
      if (wr_go) begin
         rf_d[slot] = bus_wdata;
      end else if (rd_go) begin
         case (32'(slot))
            SLOT_CTRL: begin
               rf_d[SLOT_CTRL][CTL_MTX_FLAG] = 1'b0;
               rf_d[SLOT_CTRL][CTL_DIR_FLAG] = 1'b0;
               irq_d = 1'b0;
            end
            SLOT_ENC: begin
               rf_d[SLOT_ENC][ENC_HI_OVF] = 1'b0;
               rf_d[SLOT_ENC][ENC_HI_UNF] = 1'b0;
               rf_d[SLOT_ENC][ENC_LO_OVF] = 1'b0;
               rf_d[SLOT_ENC][ENC_LO_UNF] = 1'b0;
            end
            SLOT_MTX: rf_d[SLOT_MTX][MTX_PRESS] = 1'b0;
            default: ;
         endcase
      end
      // key event updates are applied last so they win over bus actions
      if (ev_arm) rf_d[SLOT_CTRL][CTL_SINGLE_SCAN] = 1'b0;
      if (ev_irq) begin
         rf_d[SLOT_CTRL][CTL_MTX_FLAG] = 1'b1;
         irq_d = 1'b1;
      end
      for (int p = 0; p < NPAIR; p++) begin
         if (ev_take && ev_sel[p])
            rf_d[SLOT_MK0+p] = ev_rel ? '0 : (rf_d[SLOT_MK0+p] | ev_mask);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
         irq_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         for (int i = 0; i < NREG; i++) rf_q[i] <= rf_d[i];
         irq_q <= irq_d;
         if (bus_rd && !bus_wr)
            rdata_q <= hit ? rf_q[slot] : '0;
      end
   end

   for (genvar p = 0; p < NPAIR; p++) begin : g_flat
      assign mk_flat[p*DATA_W +: DATA_W] = rf_q[SLOT_MK0+p];
   end

   assign ctrl_w    = rf_q[SLOT_CTRL];
   assign bus_rdata = rdata_q;
   assign irq       = irq_q;
endmodule

// File: rtl/kpad_scan_regs.sv
module kpad_scan_regs #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int CODE_W = 8,
   parameter int ROWS   = 8,
   parameter int COLS   = 8,
   localparam int ROW_W = $clog2(ROWS),
   localparam int COL_W = $clog2(COLS),
   localparam int KEYS  = 2 ** (CODE_W - 1),
   localparam int NPAIR = COLS / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              key_valid,
   input  logic [CODE_W-1:0] key_code,
   input  logic              map_wr,
   input  logic [CODE_W-2:0] map_idx,
   input  logic              map_ok,
   input  logic [ROW_W-1:0]  map_row,
   input  logic [COL_W-1:0]  map_col,
   output logic              kp_irq
);
   if (DATA_W != 32) begin : g_bad_data
      $error("DATA_W must be 32");
   end
   if ((COLS % 2) != 0 || COLS < 2) begin : g_bad_cols
      $error("COLS must be even and at least 2");
   end
   if (ROWS > DATA_W / 2 || ROWS < 2) begin : g_bad_rows
      $error("ROWS must fit in half a word");
   end
   if (((kpad_pkg::FIXED_SLOTS + NPAIR) * 8) > 2 ** ADDR_W) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end

   logic              ent_ok;
   logic [ROW_W-1:0]  ent_row;
   logic [COL_W-1:0]  ent_col;
   logic              ev_arm, ev_take, ev_rel, ev_irq;
   logic [NPAIR-1:0]  ev_sel;
   logic [DATA_W-1:0] ev_mask;
   logic [DATA_W-1:0] ctrl_w;
   logic [NPAIR*DATA_W-1:0] mk_flat;

   kpad_keymap #(.KEYS(KEYS), .ROW_W(ROW_W), .COL_W(COL_W)) u_map (
      .clk(clk), .rst_n(rst_n),
      .ld_en(map_wr), .ld_idx(map_idx), .ld_ok(map_ok),
      .ld_row(map_row), .ld_col(map_col),
      .lk_idx(key_code[CODE_W-2:0]),
      .lk_ok(ent_ok), .lk_row(ent_row), .lk_col(ent_col)
   );

   kpad_event #(.DATA_W(DATA_W), .ROWS(ROWS), .COLS(COLS),
                .ROW_W(ROW_W), .COL_W(COL_W)) u_evt (
      .key_valid(key_valid), .key_up(key_code[CODE_W-1]), .ctrl(ctrl_w),
      .ent_ok(ent_ok), .ent_row(ent_row), .ent_col(ent_col),
      .ev_arm(ev_arm), .ev_take(ev_take), .ev_rel(ev_rel), .ev_irq(ev_irq),
      .ev_sel(ev_sel), .ev_mask(ev_mask)
   );

   kpad_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NPAIR(NPAIR)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ev_arm(ev_arm), .ev_take(ev_take), .ev_rel(ev_rel), .ev_irq(ev_irq),
      .ev_sel(ev_sel), .ev_mask(ev_mask),
      .ctrl_w(ctrl_w), .mk_flat(mk_flat), .irq(kp_irq)
   );
endmodule

// File: rtl/kpad_scan_chk.sv
module kpad_scan_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int NPAIR  = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    bus_wr,
   input logic                    bus_rd,
   input logic [ADDR_W-1:0]       bus_addr,
   input logic [DATA_W-1:0]       bus_rdata,
   input logic                    key_valid,
   input logic                    kp_irq,
   input logic [DATA_W-1:0]       ctrl_w,
   input logic [NPAIR*DATA_W-1:0] mk_flat,
   input logic                    ev_take,
   input logic                    ev_rel,
   input logic                    ev_irq,
   input logic [NPAIR-1:0]        ev_sel
);
   localparam int LAST = (6 + NPAIR) * 8;
   logic rd_only, rd_ctrl, rd_void;
   assign rd_only = bus_rd && !bus_wr;
   assign rd_ctrl = rd_only && (bus_addr == '0);
   assign rd_void = rd_only && ((bus_addr % 8) != 0 || 32'(bus_addr) >= LAST);

   // R8
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(kp_irq) |-> $past(key_valid));
   // R9
   ctrl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ctrl && !key_valid) |=> (!kp_irq && !ctrl_w[22]));
   // R12
   event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_irq |=> (kp_irq && ctrl_w[22]));
   // R3
   no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (key_valid && !ctrl_w[12] && !bus_wr) |=> $stable(mk_flat));
   // R11
   unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_void |=> (bus_rdata == '0));
   // R6
   one_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_take |-> $onehot(ev_sel));

   for (genvar p = 0; p < NPAIR; p++) begin : g_rel
      // R7
      release_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ev_take && ev_rel && ev_sel[p] && !bus_wr) |=>
            (mk_flat[p*DATA_W +: DATA_W] == '0));
   end
endmodule

bind kpad_scan_regs kpad_scan_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NPAIR(NPAIR)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_addr(bus_addr), .bus_rdata(bus_rdata), .key_valid(key_valid),
   .kp_irq(kp_irq), .ctrl_w(ctrl_w), .mk_flat(mk_flat),
   .ev_take(ev_take), .ev_rel(ev_rel), .ev_irq(ev_irq), .ev_sel(ev_sel)
);

// File: tb/tb_kpad_scan_regs.sv
module tb_kpad_scan_regs;
   localparam int CTL_ME = 32'h0000_1000, CTL_IE = 32'h0000_0800;
   localparam int CTL_AS = 32'h4000_0000, CTL_ACT = 32'h2000_0000;
   localparam int CTL_MI = 32'h0040_0000;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        bus_wr = 0, bus_rd = 0;
   logic [7:0]  bus_addr = 0;
   logic [31:0] bus_wdata = 0, bus_rdata;
   logic        key_valid = 0;
   logic [7:0]  key_code = 0;
   logic        map_wr = 0, map_ok = 0;
   logic [6:0]  map_idx = 0;
   logic [2:0]  map_row = 0, map_col = 0;
   logic        kp_irq;

   int n_run = 0, n_fail = 0;
   logic [31:0] exp_q [$];
   string       tag_q [$];
   logic        rd_pend = 0;

   always #10 clk = ~clk; // 50 MHz

   kpad_scan_regs dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .key_valid(key_valid), .key_code(key_code),
      .map_wr(map_wr), .map_idx(map_idx), .map_ok(map_ok),
      .map_row(map_row), .map_col(map_col), .kp_irq(kp_irq)
   );

   // monitor: pops the expected read data when the read result is out
   always @(posedge clk) rd_pend <= bus_rd && !bus_wr;
   always @(negedge clk) begin
      if (rd_pend) begin
         n_run++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL scoreboard empty: got %08h", bus_rdata);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (bus_rdata !== e) begin
               n_fail++;
               $display("FAIL %s: rdata %08h expected %08h", t, bus_rdata, e);
            end
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
      @(negedge clk); bus_rd = 1; bus_addr = a;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk); bus_rd = 0;
   endtask

   task automatic key(input logic [7:0] c);
      @(negedge clk); key_valid = 1; key_code = c;
      @(negedge clk); key_valid = 0;
   endtask

   task automatic load(input logic [6:0] i, input logic ok, input logic [2:0] r, input logic [2:0] c);
      @(negedge clk); map_wr = 1; map_idx = i; map_ok = ok; map_row = r; map_col = c;
      @(negedge clk); map_wr = 0;
   endtask

   task automatic chk_irq(input logic e, input string t);
      n_run++;
      if (kp_irq !== e) begin
         n_fail++;
         $display("FAIL %s: kp_irq %0b expected %0b", t, kp_irq, e);
      end
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk_irq(0, "R1 irq at reset");
      rd(8'h00, 0, "R1 ctrl reset");
      rd(8'h28, 0, "R1 mk0 reset");
      rd(8'h48, 0, "R1 debounce reset");
      // R1/R5: an unloaded entry drops the event
      wr(8'h00, CTL_ME | CTL_ACT | CTL_IE);
      key(8'h05);
      chk_irq(0, "R1 table empty after reset");
      rd(8'h28, 0, "R1 table empty mk0");
      rd(8'h00, CTL_ME | CTL_ACT | CTL_IE, "R1 no flag");
      // R13 table load
      load(7'h05, 1, 3'd2, 3'd1);
      load(7'h10, 1, 3'd7, 3'd6);
      load(7'h20, 1, 3'd0, 3'd0);
      // R3 matrix disabled
      wr(8'h00, CTL_AS | CTL_ACT | CTL_IE);
      key(8'h05);
      chk_irq(0, "R3 irq while disabled");
      rd(8'h28, 0, "R3 mk0 while disabled");
      rd(8'h00, CTL_AS | CTL_ACT | CTL_IE, "R3 ctrl untouched");
      // R4 enabled but no scan mode
      wr(8'h00, CTL_ME | CTL_IE);
      key(8'h05);
      chk_irq(0, "R4 irq without scan mode");
      rd(8'h28, 0, "R4 mk0 without scan mode");
      // R6 R8 R13 odd column press
      wr(8'h00, CTL_ME | CTL_ACT | CTL_IE);
      key(8'h05);
      chk_irq(1, "R8 irq after press");
      rd(8'h28, 32'h0004_0000, "R6 R13 row2 col1");
      rd(8'h00, CTL_ME | CTL_ACT | CTL_IE | CTL_MI, "R9 ctrl before clear");
      chk_irq(0, "R9 irq after ctrl read");
      rd(8'h00, CTL_ME | CTL_ACT | CTL_IE, "R9 ctrl after clear");
      // R6 even column and far pair
      key(8'h20);
      key(8'h10);
      rd(8'h28, 32'h0004_0001, "R6 row0 col0 merged");
      rd(8'h40, 32'h0000_0080, "R6 row7 col6");
      // R7 release
      key(8'h85);
      rd(8'h28, 0, "R7 pair cleared");
      rd(8'h40, 32'h0000_0080, "R7 other pair kept");
      // R5 invalid entry
      rd(8'h00, CTL_ME | CTL_ACT | CTL_IE | CTL_MI, "R9 clear before R5");
      key(8'h30);
      chk_irq(0, "R5 invalid entry irq");
      rd(8'h00, CTL_ME | CTL_ACT | CTL_IE, "R5 no flag");
      rd(8'h40, 32'h0000_0080, "R5 mk3 untouched");
      // R4 single scan self-clear, R8 without enable
      wr(8'h00, CTL_ME | CTL_AS);
      key(8'h20);
      chk_irq(0, "R8 no irq when disabled");
      rd(8'h00, CTL_ME, "R4 single scan cleared");
      rd(8'h28, 32'h0000_0001, "R4 press taken");
      wr(8'h00, CTL_ME | CTL_AS);
      key(8'h30);
      rd(8'h00, CTL_ME, "R4 cleared on invalid entry");
      // R2 R10 storage and read-clear
      wr(8'h08, 32'hFFFF_FFFF);
      rd(8'h08, 32'hFFFF_FFFF, "R2 direct key");
      rd(8'h08, 32'hFFFF_FFFF, "R10 direct key no clear");
      wr(8'h10, 32'hFFFF_FFFF);
      rd(8'h10, 32'hFFFF_FFFF, "R10 encoder first");
      rd(8'h10, 32'h3FFF_3FFF, "R10 encoder cleared");
      wr(8'h18, 32'hFFFF_FFFF);
      rd(8'h18, 32'hFFFF_FFFF, "R10 matrix first");
      rd(8'h18, 32'h7FFF_FFFF, "R10 matrix cleared");
      wr(8'h20, 32'h8000_0001);
      rd(8'h20, 32'h8000_0001, "R2 scan word");
      wr(8'h30, 32'h0000_DEAD);
      rd(8'h30, 32'h0000_DEAD, "R2 mk1");
      wr(8'h48, 32'h0000_1234);
      rd(8'h48, 32'h0000_1234, "R2 debounce");
      wr(8'h00, 32'h0040_0020);
      rd(8'h00, 32'h0040_0020, "R9 flags before");
      // R11 unmapped reads
      wr(8'h00, 32'h0040_0020);
      rd(8'h04, 0, "R11 unaligned");
      rd(8'h50, 0, "R11 beyond map");
      rd(8'h00, 32'h0040_0020, "R11 state kept");
      rd(8'h00, 0, "R9 flags cleared");
      // R12 read-clear and event in one cycle
      wr(8'h00, CTL_ME | CTL_ACT | CTL_IE);
      @(negedge clk);
      bus_rd = 1; bus_addr = 8'h00; key_valid = 1; key_code = 8'h20;
      exp_q.push_back(CTL_ME | CTL_ACT | CTL_IE); tag_q.push_back("R12 old value");
      @(negedge clk);
      bus_rd = 0; key_valid = 0;
      chk_irq(1, "R12 irq kept");
      rd(8'h00, CTL_ME | CTL_ACT | CTL_IE | CTL_MI, "R12 flag kept");
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule